// File: doc/BRIEF.md
# Configurable Sum-of-Products Output Macrocell

This block is one output cell of a small programmable logic array together with the AND plane that feeds it. A vector of input terms, each signal present in true and in complement form, meets a programmable connection mask to build eight product terms. Each product term can be switched off on its own. The surviving terms are ORed, optionally inverted, and then either stored in a rising-edge register or passed straight through to the pin.

Two global architecture bits and two local bits pick the cell's behaviour. One local bit selects the polarity. The other local bit and the two global bits select one of five modes:

- registered output,
- combinatorial I/O within a registered device,
- plain combinatorial output,
- input-only,
- combinatorial I/O whose output enable comes from a product term.

The mode also decides where the term fed back into the array comes from. All configuration is static and arrives on input ports.

Top module: `pal_macrocell`

## Requirements
- R1: Product term p is the AND of every input term t whose mask bit and_mask_i[p*2*N_SIG+t] is 1. A product term with no connected terms evaluates to 1.
- R2: When pt_dis_i[p] is 1, product term p is 0 wherever it is used, both in the OR sum and as an output enable.
- R3: The mode key is {glb_mode_i[0], glb_mode_i[1], loc_mode_i[0]}. When loc_mode_i[1] is 1, the data path is inverted before it reaches the pin; when it is 0, the data path is passed unchanged.
- R4: With key 010 (registered), the register captures the OR of all product terms on each rising edge of clk_i. pin_o then shows the stored value XOR loc_mode_i[1], and pin_oe_o follows oe_pin_i.
- R5: While rst_ni is low, the register holds 0. In registered mode with loc_mode_i[1]=1, pin_o therefore reads 1 and fb_o reads 0.
- R6: With key 100 (combinatorial output), pin_oe_o is 1 and pin_o is the OR of all product terms XOR loc_mode_i[1], with no clock delay. fb_o follows adj_pin_i.
- R7: With key 011 or 111 (combinatorial I/O), pin_oe_o equals product term 0. pin_o is the OR of product terms 1 to N_PT-1 XOR loc_mode_i[1]. fb_o follows pin_i.
- R8: With key 101 (input-only), and with the unused keys 000, 001 and 110, pin_oe_o is 0 and fb_o follows adj_pin_i.
- R9: Whenever pin_oe_o is 0, pin_o reads 1, modelling the pull-up on the pin.
- R10: In registered mode, fb_o is the register contents, before the polarity inversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset, models power-up |
| term_i | input | 2*N_SIG | Input term vector, true and complement forms |
| and_mask_i | input | N_PT*2*N_SIG | AND plane connections, one bit per term per product term |
| pt_dis_i | input | N_PT | Per-product-term disable |
| glb_mode_i | input | 2 | Global architecture bits: [0] first key bit, [1] second key bit |
| loc_mode_i | input | 2 | Local bits: [0] third key bit, [1] invert |
| oe_pin_i | input | 1 | Shared external output enable |
| pin_i | input | 1 | Level seen on this cell's own pin |
| adj_pin_i | input | 1 | Level seen on the adjacent cell's pin |
| pin_o | output | 1 | Pin drive value, 1 when not enabled |
| pin_oe_o | output | 1 | Pin tri-state enable |
| fb_o | output | 1 | Feedback term into the array |

## Verification
The bench targets several corner cases, each of which a wrong design would reveal:

- An empty mask row must read as 1, so a plane that defaults to 0 would hold every output at the polarity level.
- Disabling product term 0 in an I/O mode must also drop the enable. A design that masked only the sum would keep driving the pin.
- The I/O modes must leave term 0 out of the sum. A cell that summed all eight terms would show spurious highs.
- Each mode has a different feedback source. A crossed feedback mux would reflect the wrong pin, or the register, into the array.
- After reset the inverted registered pin must read high. The registered value must appear only after a clock edge; a cell that bypassed the register would match one cycle early.

// File: rtl/pal_pkg.sv
package pal_pkg;
  typedef enum logic [1:0] {OE_PIN, OE_PT, OE_ON, OE_OFF} oe_src_e;
  typedef enum logic [1:0] {FB_REG, FB_OWN, FB_ADJ} fb_src_e;

  typedef struct packed {
    oe_src_e oe_src;
    fb_src_e fb_src;
    logic    reg_out;
    logic    pt0_oe;
  } cell_cfg_t;
endpackage

// File: rtl/pal_and_plane.sv
module pal_and_plane #(
  parameter int N_TERM = 40,
  parameter int N_PT   = 8
) (
  input  logic [N_TERM-1:0]      term_i,
  input  logic [N_PT*N_TERM-1:0] mask_i,
  input  logic [N_PT-1:0]        dis_i,
  output logic [N_PT-1:0]        pt_o
);
  for (genvar p = 0; p < N_PT; p++) begin : g_pt
    logic [N_TERM-1:0] row;
    assign row     = mask_i[p*N_TERM +: N_TERM];
    // unconnected terms read as 1
    assign pt_o[p] = ~dis_i[p] & (&(term_i | ~row));
  end
endmodule

// File: rtl/pal_mode_decode.sv
module pal_mode_decode
  import pal_pkg::*;
(
  input  logic [1:0] glb_mode_i,
  input  logic       loc0_i,
  output cell_cfg_t  cfg_o
);
  logic [2:0] key;
  assign key = {glb_mode_i[0], glb_mode_i[1], loc0_i};

  always_comb begin
    cfg_o = '{oe_src: OE_OFF, fb_src: FB_ADJ, reg_out: 1'b0, pt0_oe: 1'b0};
    unique case (key)
      3'b010: cfg_o = '{oe_src: OE_PIN, fb_src: FB_REG, reg_out: 1'b1, pt0_oe: 1'b0};
      3'b011,
      3'b111: cfg_o = '{oe_src: OE_PT,  fb_src: FB_OWN, reg_out: 1'b0, pt0_oe: 1'b1};
      3'b100: cfg_o = '{oe_src: OE_ON,  fb_src: FB_ADJ, reg_out: 1'b0, pt0_oe: 1'b0};
      default: ;
    endcase
  end
endmodule

// File: rtl/pal_out_cell.sv
module pal_out_cell
  import pal_pkg::*;
#(
  parameter int N_PT = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_PT-1:0] pt_i,
  input  cell_cfg_t       cfg_i,
  input  logic            inv_i,
  input  logic            oe_pin_i,
  input  logic            pin_i,
  input  logic            adj_pin_i,
  output logic            pin_o,
  output logic            oe_o,
  output logic            fb_o
);
  logic sum_all, sum_io, q, data, drive;

  assign sum_all = |pt_i;
  assign sum_io  = |pt_i[N_PT-1:1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= 1'b0;
    else         q <= sum_all;
  end

  assign data  = cfg_i.reg_out ? q : (cfg_i.pt0_oe ? sum_io : sum_all);
  assign drive = data ^ inv_i;

  always_comb begin
    unique case (cfg_i.oe_src)
      OE_PIN:  oe_o = oe_pin_i;
      OE_PT:   oe_o = pt_i[0];
      OE_ON:   oe_o = 1'b1;
      default: oe_o = 1'b0;
    endcase
  end

  assign pin_o = oe_o ? drive : 1'b1;

  always_comb begin
    unique case (cfg_i.fb_src)
      FB_REG:  fb_o = q;
      FB_OWN:  fb_o = pin_i;
      default: fb_o = adj_pin_i;
    endcase
  end
endmodule

// File: rtl/pal_macrocell.sv
module pal_macrocell
  import pal_pkg::*;
#(
  parameter int N_SIG = 20,
  parameter int N_PT  = 8,
  localparam int N_TERM = 2 * N_SIG
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N_TERM-1:0]      term_i,
  input  logic [N_PT*N_TERM-1:0] and_mask_i,
  input  logic [N_PT-1:0]        pt_dis_i,
  input  logic [1:0]             glb_mode_i,
  input  logic [1:0]             loc_mode_i,
  input  logic                   oe_pin_i,
  input  logic                   pin_i,
  input  logic                   adj_pin_i,
  output logic                   pin_o,
  output logic                   pin_oe_o,
  output logic                   fb_o
);
  logic [N_PT-1:0] pt_eff;
  cell_cfg_t       cfg;

  pal_and_plane #(.N_TERM(N_TERM), .N_PT(N_PT)) u_plane (
    .term_i (term_i),
    .mask_i (and_mask_i),
    .dis_i  (pt_dis_i),
    .pt_o   (pt_eff)
  );

  pal_mode_decode u_dec (
    .glb_mode_i (glb_mode_i),
    .loc0_i     (loc_mode_i[0]),
    .cfg_o      (cfg)
  );

  pal_out_cell #(.N_PT(N_PT)) u_cell (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pt_i      (pt_eff),
    .cfg_i     (cfg),
    .inv_i     (loc_mode_i[1]),
    .oe_pin_i  (oe_pin_i),
    .pin_i     (pin_i),
    .adj_pin_i (adj_pin_i),
    .pin_o     (pin_o),
    .oe_o      (pin_oe_o),
    .fb_o      (fb_o)
  );
endmodule

// File: rtl/pal_macrocell_chk.sv
module pal_macrocell_chk #(
  parameter int N_PT = 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [1:0]      glb_mode_i,
  input logic            loc0_i,
  input logic            oe_pin_i,
  input logic            pin_i,
  input logic            adj_pin_i,
  input logic [N_PT-1:0] pt_eff,
  input logic            pin_o,
  input logic            pin_oe_o,
  input logic            fb_o
);
  logic [2:0] key;
  assign key = {glb_mode_i[0], glb_mode_i[1], loc0_i};

  p_reg_oe_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key == 3'b010) |-> (pin_oe_o == oe_pin_i));

  p_comb_on_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key == 3'b100) |-> (pin_oe_o && fb_o == adj_pin_i));

  p_pt_oe_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key == 3'b011 || key == 3'b111) |-> (pin_oe_o == pt_eff[0] && fb_o == pin_i));

  p_input_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key == 3'b101) |-> (!pin_oe_o && fb_o == adj_pin_i));

  p_pullup_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pin_oe_o |-> pin_o);

  p_reg_fb_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key == 3'b010) |=> (key != 3'b010 || fb_o == $past(|pt_eff)));
endmodule

bind pal_macrocell pal_macrocell_chk #(.N_PT(N_PT)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .glb_mode_i (glb_mode_i),
  .loc0_i     (loc_mode_i[0]),
  .oe_pin_i   (oe_pin_i),
  .pin_i      (pin_i),
  .adj_pin_i  (adj_pin_i),
  .pt_eff     (pt_eff),
  .pin_o      (pin_o),
  .pin_oe_o   (pin_oe_o),
  .fb_o       (fb_o)
);

// File: tb/tb_pal_macrocell.sv
`timescale 1ns/1ps
module tb_pal_macrocell;
  localparam int NS = 20;
  localparam int NT = 2 * NS;
  localparam int NP = 8;

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic [NT-1:0]  term_i = '0;
  logic [NP*NT-1:0] and_mask_i = '0;
  logic [NP-1:0]  pt_dis_i = '0;
  logic [1:0]     glb_mode_i = 2'b00;
  logic [1:0]     loc_mode_i = 2'b00;
  logic           oe_pin_i = 1'b0, pin_i = 1'b0, adj_pin_i = 1'b0;
  logic           pin_o, pin_oe_o, fb_o;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk_i = ~clk_i;

  pal_macrocell #(.N_SIG(NS), .N_PT(NP)) dut (.*);

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  function automatic logic [NP-1:0] ref_pt(input logic [NP*NT-1:0] m,
                                           input logic [NT-1:0] t,
                                           input logic [NP-1:0] d);
    logic [NP-1:0] r;
    for (int p = 0; p < NP; p++) begin
      r[p] = ~d[p];
      for (int k = 0; k < NT; k++)
        if (m[p*NT+k] && !t[k]) r[p] = 1'b0;
    end
    return r;
  endfunction

  task automatic set_mode(input logic [2:0] key, input logic inv);
    glb_mode_i = {key[1], key[2]};
    loc_mode_i = {inv, key[0]};
  endtask

  task automatic randomize_inputs();
    and_mask_i = '0;
    for (int p = 0; p < NP; p++)
      repeat ($urandom % 3) and_mask_i[p*NT + ($urandom % NT)] = 1'b1;
    term_i    = {$urandom, $urandom};
    pt_dis_i  = NP'($urandom % 4 == 0 ? $urandom : 0);
    pin_i     = 1'($urandom);
    adj_pin_i = 1'($urandom);
    oe_pin_i  = 1'($urandom);
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    set_mode(3'b010, 1'b1);
    oe_pin_i = 1'b1;
    and_mask_i = '0;
    pt_dis_i = '0;
    #20;
    check("R5 reset pin", pin_o, 1'b1);
    check("R5 reset fb", fb_o, 1'b0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    check("R5 after release pin", pin_o, 1'b1);
  endtask

  task automatic t_registered();
    logic [NP-1:0] pt;
    logic s;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk_i);
      randomize_inputs();
      set_mode(3'b010, 1'($urandom));
      pt = ref_pt(and_mask_i, term_i, pt_dis_i);
      s = |pt;
      @(posedge clk_i);
      #1;
      check("R4 reg oe", pin_oe_o, oe_pin_i);
      check("R4 R9 reg pin", pin_o, oe_pin_i ? (s ^ loc_mode_i[1]) : 1'b1);
      check("R10 reg fb", fb_o, s);
    end
  endtask

  task automatic t_reg_delay();
    @(negedge clk_i);
    set_mode(3'b010, 1'b0);
    oe_pin_i = 1'b1;
    pt_dis_i = '1;
    @(posedge clk_i);
    #1;
    check("R4 reg low", pin_o, 1'b0);
    @(negedge clk_i);
    pt_dis_i = '0;
    and_mask_i = '0;
    #1;
    check("R4 no change before edge", pin_o, 1'b0);
    @(posedge clk_i);
    #1;
    check("R4 change after edge", pin_o, 1'b1);
  endtask

  task automatic t_comb();
    logic [NP-1:0] pt;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk_i);
      randomize_inputs();
      set_mode(3'b100, 1'($urandom));
      pt = ref_pt(and_mask_i, term_i, pt_dis_i);
      #1;
      check("R6 comb oe", pin_oe_o, 1'b1);
      check("R6 comb pin", pin_o, (|pt) ^ loc_mode_i[1]);
      check("R6 comb fb", fb_o, adj_pin_i);
    end
  endtask

  task automatic t_comb_io();
    logic [NP-1:0] pt;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk_i);
      randomize_inputs();
      set_mode((i % 2) ? 3'b111 : 3'b011, 1'($urandom));
      pt = ref_pt(and_mask_i, term_i, pt_dis_i);
      #1;
      check("R7 io oe", pin_oe_o, pt[0]);
      check("R7 R9 io pin", pin_o, pt[0] ? ((|pt[NP-1:1]) ^ loc_mode_i[1]) : 1'b1);
      check("R7 io fb", fb_o, pin_i);
    end
    // term 0 true, all others false: pin shows polarity only
    @(negedge clk_i);
    set_mode(3'b111, 1'b0);
    and_mask_i = '0;
    pt_dis_i = {{(NP-1){1'b1}}, 1'b0};
    #1;
    check("R7 pt0 excluded from sum", pin_o, 1'b0);
    check("R7 pt0 enables", pin_oe_o, 1'b1);
    pt_dis_i = '0;
    pt_dis_i[0] = 1'b1;
    #1;
    check("R2 disabled pt0 drops oe", pin_oe_o, 1'b0);
    check("R9 pulled high", pin_o, 1'b1);
  endtask

  task automatic t_input();
    logic [2:0] keys [4] = '{3'b101, 3'b000, 3'b001, 3'b110};
    for (int i = 0; i < 16; i++) begin
      @(negedge clk_i);
      randomize_inputs();
      set_mode(keys[i % 4], 1'($urandom));
      and_mask_i = '0;
      pt_dis_i = '0;
      #1;
      check("R8 input oe", pin_oe_o, 1'b0);
      check("R8 R9 input pin", pin_o, 1'b1);
      check("R8 input fb", fb_o, adj_pin_i);
    end
  endtask

  task automatic t_plane();
    @(negedge clk_i);
    set_mode(3'b100, 1'b0);
    and_mask_i = '0;
    pt_dis_i = '1;
    #1;
    check("R2 all disabled", pin_o, 1'b0);
    pt_dis_i[5] = 1'b0;
    #1;
    check("R1 empty row is one", pin_o, 1'b1);
    set_mode(3'b100, 1'b1);
    #1;
    check("R3 inverted", pin_o, 1'b0);
    set_mode(3'b100, 1'b0);
    and_mask_i[5*NT + 7] = 1'b1;
    and_mask_i[5*NT + 30] = 1'b1;
    term_i = '0;
    term_i[7] = 1'b1;
    #1;
    check("R1 one term missing", pin_o, 1'b0);
    term_i[30] = 1'b1;
    #1;
    check("R1 all terms present", pin_o, 1'b1);
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    t_reset();
    t_reg_delay();
    t_registered();
    t_comb();
    t_comb_io();
    t_input();
    t_plane();
    #10;
    finish_up();
  end
endmodule